// File: doc/BRIEF.md
# Flash Operation Status Bit Generator

This block forms the status byte that a NOR-style flash presents on its data bus in place of array contents while an internal program or erase algorithm is running. The command decoder and the algorithm sequencer report which operation is under way, whether it is busy, whether the sector-erase accept window is still open, whether the erase is suspended, and whether the time limit has been exceeded. The block combines these with a read strobe and a flag saying whether the current read address lies in a sector marked for erase.

Two bits must change from one read to the next. Each is held in a toggle flip-flop that advances after the read that shows its value. A new operation clears both flip-flops. When no algorithm is active and the part is not suspended, or when a suspended part is read outside the erasing sectors, the valid output is low and the read path selects array data instead.

Top module: `flash_status_gen`

## Requirements
- R1: While `busy_i` is high and `op_kind_i` is 2'b00 (byte program), status bit 7 is the inverse of `prog_bit7_i` and `stat_valid_o` is high.
- R2: While an erase is active (`op_kind_i` 2'b01 chip erase or 2'b10 sector erase, with `busy_i` or `erase_win_i` high), status bit 7 reads 0.
- R3: While `busy_i` or `erase_win_i` is high, status bit 6 shows a flip-flop that inverts in the cycle after each cycle in which `rd_strobe_i` is high. The read that raises the strobe sees the value from before the flip.
- R4: Status bit 5 equals `over_time_i` while an algorithm is active, and bits 7 and 6 keep the in-progress pattern of R1 through R3.
- R5: Status bit 3 reads 0 during a sector erase while `erase_win_i` is high, and 1 once `erase_win_i` is low. It reads 1 for chip erase and 0 for byte program.
- R6: With `suspend_i` high, `busy_i` and `erase_win_i` low and `in_erase_sec_i` high, the status is valid, bit 7 is 1, and bit 6 holds its last value. Bit 2 shows a flip-flop that inverts after each such strobed read.
- R7: With `suspend_i` high, `busy_i` and `erase_win_i` low and `in_erase_sec_i` low, `stat_valid_o` is low, and strobed reads there do not advance the bit 2 flip-flop.
- R8: A byte program that runs while `suspend_i` is high reports bit 7 and bit 6 exactly as in R1 and R3.
- R9: When `busy_i`, `erase_win_i` and `suspend_i` are all low, `stat_valid_o` is low and `status_o` is 8'h00.
- R10: A cycle with `op_start_i` high clears both toggle flip-flops to 0. This takes priority over a strobe in the same cycle.
- R11: After reset, both toggle flip-flops are 0 and `stat_valid_o` is low. Bits 4, 1 and 0 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start_i | input | 1 | One-cycle pulse when a new operation begins |
| op_kind_i | input | 2 | 00 byte program, 01 chip erase, 10 sector erase |
| busy_i | input | 1 | Algorithm executing |
| erase_win_i | input | 1 | Sector-erase accept window open |
| suspend_i | input | 1 | Sector erase suspended |
| over_time_i | input | 1 | Time limit exceeded |
| prog_bit7_i | input | 1 | Bit 7 of the byte being programmed |
| rd_strobe_i | input | 1 | One-cycle read strobe |
| in_erase_sec_i | input | 1 | Read address lies in a sector being erased |
| status_o | output | 8 | Status byte |
| stat_valid_o | output | 1 | High when status replaces array data |

## Verification
On every cycle the assertions check the following: the polarity of bit 7 for program and erase, that the output drops when the part is idle or when a suspended part is read outside the erasing sector, and that each toggle flips or holds as its strobe and clear dictate. Only the bench scenarios can show the exact byte sequences over several reads. These include the bit 3 change when the window closes, the time-limit flag riding on a still-toggling bit 6, bit 6 frozen while bit 2 toggles in suspend, bit 2 untouched by reads of other sectors, and a suspended program restarting the toggle from 0.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
    localparam int STAT_W  = 8;
    localparam int BIT_DP  = 7;
    localparam int BIT_TG  = 6;
    localparam int BIT_TO  = 5;
    localparam int BIT_TMR = 3;
    localparam int BIT_ST  = 2;

    typedef enum logic [1:0] {
        OP_PROG  = 2'b00,
        OP_CHIP  = 2'b01,
        OP_SECT  = 2'b10,
        OP_RSVD  = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic t6;
        logic t2;
    } tog_state_t;
endpackage

// File: rtl/fsg_toggles.sv
module fsg_toggles
    import flash_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic adv6_i,
    input  logic adv2_i,
    output logic tog6_o,
    output logic tog2_o
);
    tog_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d = '0;
        end else begin
            if (adv6_i) s_d.t6 = ~s_q.t6;
            if (adv2_i) s_d.t2 = ~s_q.t2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tog6_o = s_q.t6;
    assign tog2_o = s_q.t2;

    // R10: a start pulse leaves both toggles at zero
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!tog6_o && !tog2_o));
    // R3: each strobed read during an algorithm flips bit 6
    a_r3_flip6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv6_i && !clear_i) |=> (tog6_o != $past(tog6_o)));
    // R6: bit 6 holds when not advanced
    a_r6_hold6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv6_i && !clear_i) |=> $stable(tog6_o));
    // R7: bit 2 holds when not advanced
    a_r7_hold2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv2_i && !clear_i) |=> $stable(tog2_o));
endmodule

// File: rtl/fsg_mux.sv
module fsg_mux
    import flash_status_pkg::*;
(
    input  logic [1:0]        op_kind_i,
    input  logic              busy_i,
    input  logic              erase_win_i,
    input  logic              suspend_i,
    input  logic              over_time_i,
    input  logic              prog_bit7_i,
    input  logic              in_erase_sec_i,
    input  logic              tog6_i,
    input  logic              tog2_i,
    output logic [STAT_W-1:0] status_o,
    output logic              valid_o
);
    op_kind_e kind;
    logic     active;

    always_comb begin
        kind     = op_kind_e'(op_kind_i);
        active   = busy_i | erase_win_i;
        status_o = '0;
        valid_o  = 1'b0;
        if (active) begin
            valid_o          = 1'b1;
            status_o[BIT_TG] = tog6_i;
            status_o[BIT_TO] = over_time_i;
            status_o[BIT_ST] = tog2_i;
            if (kind == OP_PROG) begin
                status_o[BIT_DP]  = ~prog_bit7_i;
                status_o[BIT_TMR] = 1'b0;
            end else begin
                status_o[BIT_DP]  = 1'b0;
                status_o[BIT_TMR] = (kind == OP_CHIP) | ~erase_win_i;
            end
        end else if (suspend_i && in_erase_sec_i) begin
            valid_o          = 1'b1;
            status_o[BIT_DP] = 1'b1;
            status_o[BIT_TG] = tog6_i;
            status_o[BIT_ST] = tog2_i;
        end
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start_i,
    input  logic [1:0] op_kind_i,
    input  logic       busy_i,
    input  logic       erase_win_i,
    input  logic       suspend_i,
    input  logic       over_time_i,
    input  logic       prog_bit7_i,
    input  logic       rd_strobe_i,
    input  logic       in_erase_sec_i,
    output logic [7:0] status_o,
    output logic       stat_valid_o
);
    logic adv6, adv2, tog6, tog2;

    assign adv6 = rd_strobe_i & (busy_i | erase_win_i);
    assign adv2 = rd_strobe_i & suspend_i & in_erase_sec_i;

    fsg_toggles u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (op_start_i),
        .adv6_i  (adv6),
        .adv2_i  (adv2),
        .tog6_o  (tog6),
        .tog2_o  (tog2)
    );

    fsg_mux u_mux (
        .op_kind_i      (op_kind_i),
        .busy_i         (busy_i),
        .erase_win_i    (erase_win_i),
        .suspend_i      (suspend_i),
        .over_time_i    (over_time_i),
        .prog_bit7_i    (prog_bit7_i),
        .in_erase_sec_i (in_erase_sec_i),
        .tog6_i         (tog6),
        .tog2_i         (tog2),
        .status_o       (status_o),
        .valid_o        (stat_valid_o)
    );

    // R1: program shows inverted data on bit 7
    a_r1_prog_dp: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && op_kind_i == 2'b00) |-> (stat_valid_o && status_o[7] == !prog_bit7_i));
    // R2: erase shows 0 on bit 7
    a_r2_erase_dp: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy_i || erase_win_i) && (op_kind_i == 2'b01 || op_kind_i == 2'b10)) |-> !status_o[7]);
    // R7: suspended read outside erasing sector yields array data
    a_r7_other_sec: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend_i && !busy_i && !erase_win_i && !in_erase_sec_i) |-> !stat_valid_o);
    // R9: idle part drives no status
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !erase_win_i && !suspend_i) |-> (!stat_valid_o && status_o == 8'h00));
    // R11: unused bits stay low
    a_r11_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[4] == 1'b0 && status_o[1:0] == 2'b00));
endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       op_start_i = 0;
    logic [1:0] op_kind_i = 2'b00;
    logic       busy_i = 0, erase_win_i = 0, suspend_i = 0, over_time_i = 0;
    logic       prog_bit7_i = 0, rd_strobe_i = 0, in_erase_sec_i = 0;
    logic [7:0] status_o;
    logic       stat_valid_o;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    flash_status_gen dut (.*);

    task automatic chk(input string req, input logic v, input logic [7:0] s,
                       input logic ev, input logic [7:0] es);
        n_run++;
        if (v !== ev || (ev && s !== es)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b status=%02h expected valid=%0b status=%02h",
                     req, v, s, ev, es);
        end
    endtask

    task automatic read_chk(input string req, input logic ev, input logic [7:0] es);
        rd_strobe_i = 1;
        @(negedge clk);
        chk(req, stat_valid_o, status_o, ev, es);
        @(posedge clk); #1;
        rd_strobe_i = 0;
    endtask

    task automatic start_op(input logic [1:0] k);
        op_kind_i = k; op_start_i = 1;
        @(posedge clk); #1;
        op_start_i = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11 reset", stat_valid_o, status_o, 1'b0, 8'h00);
        chk("R9 idle", stat_valid_o, status_o, 1'b0, 8'h00);
    endtask

    task automatic t_program;
        busy_i = 1; prog_bit7_i = 1;
        start_op(2'b00);
        read_chk("R1 prog first read", 1, 8'h00);
        read_chk("R3 prog toggle", 1, 8'h40);
        prog_bit7_i = 0;
        read_chk("R1 prog bit7 inverted", 1, 8'h80);
        busy_i = 0; #1;
        read_chk("R9 done idle", 0, 8'h00);
    endtask

    task automatic t_sector;
        erase_win_i = 1;
        start_op(2'b10);
        read_chk("R5 window open", 1, 8'h00);
        read_chk("R3 window toggle", 1, 8'h40);
        erase_win_i = 0; busy_i = 1;
        read_chk("R5 erase started", 1, 8'h08);
        over_time_i = 1;
        read_chk("R4 time exceeded", 1, 8'h68);
        read_chk("R4 still toggling", 1, 8'h28);
        over_time_i = 0; busy_i = 0;
    endtask

    task automatic t_chip;
        busy_i = 1;
        rd_strobe_i = 1;
        start_op(2'b01);
        rd_strobe_i = 0;
        read_chk("R10 cleared with strobe", 1, 8'h08);
        read_chk("R2 chip toggle", 1, 8'h48);
        busy_i = 0;
    endtask

    task automatic t_suspend;
        busy_i = 1;
        start_op(2'b10);
        read_chk("R2 sector busy", 1, 8'h08);
        busy_i = 0; suspend_i = 1; in_erase_sec_i = 1;
        read_chk("R6 suspended sector", 1, 8'hC0);
        read_chk("R6 bit2 toggles", 1, 8'hC4);
        read_chk("R6 bit6 held", 1, 8'hC0);
        in_erase_sec_i = 0;
        read_chk("R7 other sector", 0, 8'h00);
        in_erase_sec_i = 1;
        read_chk("R7 bit2 not advanced", 1, 8'hC4);
        in_erase_sec_i = 0;
    endtask

    task automatic t_susp_prog;
        busy_i = 1; prog_bit7_i = 1;
        start_op(2'b00);
        read_chk("R8 suspended program", 1, 8'h00);
        read_chk("R8 suspended program toggle", 1, 8'h40);
        prog_bit7_i = 0;
        read_chk("R8 suspended program bit7", 1, 8'h80);
        busy_i = 0;
        read_chk("R7 after suspended program", 0, 8'h00);
        suspend_i = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_program();
        t_sector();
        t_chip();
        t_suspend();
        t_susp_prog();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule